// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block derives a slower clock for one clock domain from a faster input clock. Each output period has two parts. First comes a low phase that lasts one cycle more than a programmable wait count. Then comes a high phase that lasts one cycle more than a programmable hold count. The division ratio is therefore the sum of the two counts plus two. Software normally splits a wanted ratio evenly: the wait count is half the ratio minus one, and the hold count takes the rest.

One configuration word holds the two counts, a pass-through (bypass) flag and an apply flag. Written counts are only staged. They reach the divider when software also sets the apply flag. That flag reads back as 1 until the staged counts have been taken over at the end of a complete high phase, and then it clears by itself. The bypass flag routes the input clock straight to the output. It also changes only at a period boundary.

The count field width is a parameter. The default is 4 bits, which gives ratios 2 to 32. A narrower 3-bit build gives ratios 2 to 16 and ignores the top bit of each field.

Top module: `wait_hold_clk_div`

## Requirements
- R1: After synchronous reset, both counts, the bypass flag and the apply flag are 0. The read word is 0 and the output divides by 2, starting with its low phase.
- R2: In divide mode, each low phase of the output lasts exactly (active wait count + 1) input cycles.
- R3: In divide mode, each high phase lasts exactly (active hold count + 1) input cycles, so one output period is (wait + hold + 2) input cycles.
- R4: A write with bit 25 clear updates the staged counts, which are visible on the read word. It leaves the active divide ratio unchanged.
- R5: A write with bit 25 set makes read bit 25 equal 1 from the next cycle on. The bit clears when the staged counts are applied, no more than one old output period (old ratio input cycles) after the write.
- R6: Staged counts are applied only at the end of a complete high phase. The output period in progress is never shortened or stretched. The first low phase after the switch already uses the new wait count.
- R7: Bit 24 selects bypass, where the output equals the input clock. Bypass is entered or left only at a period boundary: the end of a high phase, or any cycle while bypass is active. Bypass does not need bit 25. On leaving bypass, the output starts with a full low phase.
- R8: Field positions in the written and read word: wait count at bits 16 and up, hold count at bits 20 and up, bypass at bit 24, apply request at bit 25. Every other read bit is 0. Field bits above the count width are ignored and read 0.
- R9: With a 3-bit count width, the ratio range is 2 to 16. Writing 15 to a field acts as 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Configuration word to write |
| rd_data_o | output | 32 | Current configuration word (staged fields and apply flag) |
| div_clk_o | output | 1 | Divided or bypassed output clock |

## Verification
The bench builds two copies side by side: one with the default 4-bit count width and one with the 3-bit width. Both receive identical writes. The wide copy lets the bench sweep every ratio from 2 to 32 and measure both phase widths. The narrow copy shows that the same all-ones fields fold down to a ratio of 16 and that unused field bits read back as 0. Apply requests are issued at arbitrary points inside periods, so the bench sees counts switching only at the end of a high phase. It also times how long the apply flag stays set.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int REG_W     = 32;
    localparam int MAX_CNT_W = 4;
    localparam int WAIT_LSB  = 16;
    localparam int HOLD_LSB  = 20;
    localparam int BYP_BIT   = 24;
    localparam int UPD_BIT   = 25;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [MAX_CNT_W-1:0] wait_cnt;
        logic [MAX_CNT_W-1:0] hold_cnt;
        logic                 bypass;
    } div_cfg_t;

    function automatic logic [MAX_CNT_W-1:0] field_mask(input int cnt_w);
        logic [MAX_CNT_W-1:0] m;
        for (int i = 0; i < MAX_CNT_W; i++) begin
            m[i] = (i < cnt_w);
        end
        return m;
    endfunction

    function automatic div_cfg_t decode_word(input logic [REG_W-1:0] w, input int cnt_w);
        div_cfg_t c;
        c.wait_cnt = w[WAIT_LSB +: MAX_CNT_W] & field_mask(cnt_w);
        c.hold_cnt = w[HOLD_LSB +: MAX_CNT_W] & field_mask(cnt_w);
        c.bypass   = w[BYP_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_word(input div_cfg_t c, input logic req);
        logic [REG_W-1:0] w;
        w = '0;
        w[WAIT_LSB +: MAX_CNT_W] = c.wait_cnt;
        w[HOLD_LSB +: MAX_CNT_W] = c.hold_cnt;
        w[BYP_BIT] = c.bypass;
        w[UPD_BIT] = req;
        return w;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             boundary_i,
    output div_cfg_t         staged_o,
    output logic             req_o,
    output logic [REG_W-1:0] rd_data_o
);

    div_cfg_t staged_q;
    logic     req_q;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^{wr_data_i[REG_W-1:UPD_BIT+1], wr_data_i[WAIT_LSB-1:0]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            staged_q <= '0;
            req_q    <= 1'b0;
        end else begin
            if (boundary_i && req_q) begin
                req_q <= 1'b0;
            end
            if (wr_en_i) begin
                staged_q <= decode_word(wr_data_i, CNT_W);
                if (wr_data_i[UPD_BIT]) begin
                    req_q <= 1'b1;
                end
            end
        end
    end

    assign staged_o  = staged_q;
    assign req_o     = req_q;
    assign rd_data_o = encode_word(staged_q, req_q);

    // R5
    req_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(req_q) |-> $past(boundary_i));

    // R5
    req_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_data_i[UPD_BIT]) |=> req_q);

endmodule

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  div_cfg_t staged_i,
    input  logic     req_i,
    output logic     boundary_o,
    output logic     bypass_o,
    output logic     high_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    div_cfg_t         act_q;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             low_done;
    logic             high_done;

    assign low_done   = (phase_q == PH_LOW)  && (cnt_q == act_q.wait_cnt[CNT_W-1:0]);
    assign high_done  = (phase_q == PH_HIGH) && (cnt_q == act_q.hold_cnt[CNT_W-1:0]);
    assign boundary_o = act_q.bypass || high_done;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q   <= '0;
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (boundary_o) begin
            act_q.bypass <= staged_i.bypass;
            if (req_i) begin
                act_q.wait_cnt <= staged_i.wait_cnt;
                act_q.hold_cnt <= staged_i.hold_cnt;
            end
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (low_done) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign bypass_o = act_q.bypass;
    assign high_o   = (phase_q == PH_HIGH);

    // R2
    low_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_HIGH && $past(phase_q) == PH_LOW)
            |-> ($past(cnt_q) == $past(act_q.wait_cnt[CNT_W-1:0])));

    // R3
    high_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_LOW && $past(phase_q) == PH_HIGH)
            |-> ($past(cnt_q) == $past(act_q.hold_cnt[CNT_W-1:0])));

    // R6
    cnt_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(act_q.wait_cnt) || !$stable(act_q.hold_cnt))
            |-> $past(boundary_o && req_i));

    // R7
    byp_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_q.bypass) |-> $past(boundary_o));

    // R7
    byp_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        act_q.bypass |-> (phase_q == PH_LOW && cnt_q == '0));

endmodule

// File: rtl/clkdiv_out_sel.sv
module clkdiv_out_sel (
    input  logic clk_i,
    input  logic bypass_i,
    input  logic high_i,
    output logic clk_o
);

    assign clk_o = bypass_i ? clk_i : high_i;

endmodule

// File: rtl/wait_hold_clk_div.sv
module wait_hold_clk_div
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        div_clk_o
);

    div_cfg_t staged;
    logic     req;
    logic     boundary;
    logic     bypass;
    logic     high;

    clkdiv_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .boundary_i (boundary),
        .staged_o   (staged),
        .req_o      (req),
        .rd_data_o  (rd_data_o)
    );

    clkdiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .staged_i   (staged),
        .req_i      (req),
        .boundary_o (boundary),
        .bypass_o   (bypass),
        .high_o     (high)
    );

    clkdiv_out_sel u_sel (
        .clk_i    (clk_i),
        .bypass_i (bypass),
        .high_i   (high),
        .clk_o    (div_clk_o)
    );

    // R8
    rd_field_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_data_o[WAIT_LSB+MAX_CNT_W-1:WAIT_LSB+CNT_W] == '0 || CNT_W == MAX_CNT_W)
        && rd_data_o[31:26] == '0 && rd_data_o[15:0] == '0);

endmodule

// File: tb/wait_hold_clk_div_tb.sv
`timescale 1ns/1ps
module wait_hold_clk_div_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd4, rd3;
    logic        out4, out3;

    always #2.5 clk = ~clk;

    wait_hold_clk_div #(.CNT_W(4)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd4), .div_clk_o(out4));

    wait_hold_clk_div #(.CNT_W(3)) dut3_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd3), .div_clk_o(out3));

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    done = 1'b0;
    bit    cmp_en = 1'b0;

    // reference model state, index 0 = 4-bit build, 1 = 3-bit build
    int m_sw[2], m_sh[2], m_sb[2], m_req[2];
    int m_aw[2], m_ah[2], m_ab[2], m_lvl[2], m_left[2];
    int msk[2] = '{15, 7};

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_sw[k] = 0; m_sh[k] = 0; m_sb[k] = 0; m_req[k] = 0;
                m_aw[k] = 0; m_ah[k] = 0; m_ab[k] = 0; m_lvl[k] = 0; m_left[k] = 1;
            end else begin
                if (m_ab[k] != 0 || (m_lvl[k] == 1 && m_left[k] == 1)) begin
                    if (m_req[k] != 0) begin
                        m_aw[k] = m_sw[k]; m_ah[k] = m_sh[k]; m_req[k] = 0;
                    end
                    m_ab[k] = m_sb[k];
                    m_lvl[k] = 0;
                    m_left[k] = m_aw[k] + 1;
                end else if (m_lvl[k] == 0 && m_left[k] == 1) begin
                    m_lvl[k] = 1;
                    m_left[k] = m_ah[k] + 1;
                end else begin
                    m_left[k] = m_left[k] - 1;
                end
                if (wr_en) begin
                    m_sw[k] = int'(wr_data[19:16]) & msk[k];
                    m_sh[k] = int'(wr_data[23:20]) & msk[k];
                    m_sb[k] = int'(wr_data[24]);
                    if (wr_data[25]) m_req[k] = 1;
                end
            end
        end
    endtask

    function automatic longint exp_rd(int k);
        return (longint'(m_req[k]) << 25) | (longint'(m_sb[k]) << 24) |
               (longint'(m_sh[k]) << 20) | (longint'(m_sw[k]) << 16);
    endfunction

    task automatic compare(bit clk_high);
        chk("out w4", out4, (m_ab[0] != 0) ? clk_high : m_lvl[0]);
        chk("out w3", out3, (m_ab[1] != 0) ? clk_high : m_lvl[1]);
        chk("rd w4", rd4, exp_rd(0));
        chk("rd w3", rd3, exp_rd(1));
    endtask

    always begin
        @(posedge clk);
        model_step();
        cmp_en = 1'b1;
        #1;
        if (cmp_en && !done) compare(1'b1);
        @(negedge clk);
        #1;
        if (cmp_en && !done) compare(1'b0);
    end

    function automatic logic [31:0] cfg(int w, int h, bit b, bit u);
        return (32'(u) << 25) | (32'(b) << 24) | (32'(h) << 20) | (32'(w) << 16);
    endfunction

    task automatic write_reg(logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_req_clear(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            n++;
            if (rd4[25] == 1'b0) break;
        end
    endtask

    function automatic logic pick(int sel);
        return (sel == 0) ? out4 : out3;
    endfunction

    task automatic measure(int sel, output int hi_n, output int lo_n);
        hi_n = 0; lo_n = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (pick(sel) == 1'b0) break;
        end
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (pick(sel) == 1'b1) break;
        end
        for (int i = 0; i < 100; i++) begin
            hi_n++;
            @(posedge clk); #1;
            if (pick(sel) == 1'b0) break;
        end
        for (int i = 0; i < 100; i++) begin
            lo_n++;
            @(posedge clk); #1;
            if (pick(sel) == 1'b1) break;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog %s actual=timeout expected=finish", tag);
            finish_run();
        end
    end

    initial begin
        int hi_n, lo_n, n, prev_ratio;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and divide by two
        tag = "R1";
        chk("rd w4 after reset", rd4, 0);
        chk("rd w3 after reset", rd3, 0);
        chk("out low after reset", out4, 0);
        measure(0, hi_n, lo_n);
        chk("reset high width", hi_n, 1);
        chk("reset low width", lo_n, 1);

        // R2 R3 R5: sweep all legal ratios of the 4-bit build
        prev_ratio = 2;
        for (int r = 2; r <= 32; r++) begin
            int wt, hd;
            wt = r / 2 - 1;
            hd = r - wt - 2;
            tag = "R5";
            write_reg(cfg(wt, hd, 1'b0, 1'b1));
            wait_req_clear(n);
            chk("apply clears within old period", (n <= prev_ratio) ? 1 : 0, 1);
            tag = "R3";
            measure(0, hi_n, lo_n);
            chk("high width", hi_n, hd + 1);
            tag = "R2";
            chk("low width", lo_n, wt + 1);
            prev_ratio = r;
        end

        // R4: staged counts without apply leave ratio unchanged
        tag = "R4";
        write_reg(cfg(2, 3, 1'b0, 1'b0));
        chk("staged readback", rd4, 32'h0032_0000);
        measure(0, hi_n, lo_n);
        chk("old high width kept", hi_n, 16);
        chk("old low width kept", lo_n, 16);

        // R6: apply mid-period, switch only at end of high phase
        tag = "R6";
        repeat (5) @(negedge clk);
        write_reg(cfg(2, 3, 1'b0, 1'b1));
        wait_req_clear(n);
        measure(0, hi_n, lo_n);
        chk("new high width", hi_n, 4);
        chk("new low width", lo_n, 3);

        // R7: bypass entry and exit
        tag = "R7";
        write_reg(cfg(2, 3, 1'b1, 1'b0));
        repeat (12) @(negedge clk);
        @(posedge clk); #1;
        chk("bypass follows clk high", out4, 1);
        @(negedge clk); #1;
        chk("bypass follows clk low", out4, 0);
        write_reg(cfg(2, 3, 1'b0, 1'b0));
        measure(0, hi_n, lo_n);
        chk("post-bypass high width", hi_n, 4);
        chk("post-bypass low width", lo_n, 3);

        // R8: field placement and masking
        tag = "R8";
        write_reg(32'hFFFF_FFFF);
        chk("all-ones readback w4", rd4, 32'h03FF_0000);
        chk("all-ones readback w3", rd3, 32'h0377_0000);
        write_reg(cfg(1, 0, 1'b0, 1'b1));
        wait_req_clear(n);
        measure(0, hi_n, lo_n);
        chk("ratio 3 high width", hi_n, 1);
        chk("ratio 3 low width", lo_n, 2);

        // R9: 3-bit build folds wide fields
        tag = "R9";
        write_reg(cfg(15, 15, 1'b0, 1'b1));
        wait_req_clear(n);
        repeat (40) @(negedge clk);
        measure(1, hi_n, lo_n);
        chk("narrow high width", hi_n, 8);
        chk("narrow low width", lo_n, 8);
        measure(0, hi_n, lo_n);
        chk("wide high width", hi_n, 16);
        chk("wide low width", lo_n, 16);

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule